// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the 256-byte configuration space of a single PCI function. Requests arrive on a plain synchronous port: a byte offset, a size code and, for writes, a 32-bit data word. Reads are combinational: the read data follows the offset and size inputs in the same cycle. Writes take effect at the clock edge when the request is valid and marked as a write. A per-byte protection map, selected by the header-type byte, decides which bytes software can change.

Base address registers take special handling. A dword write to a register whose region has a nonzero size is masked to that size, and the region's type bits are merged back in. The expansion ROM register keeps its enable bit. For each of the seven regions (six base registers and the ROM), the block keeps a registered decoded base address and a valid flag. These are recomputed only after a base-register write or a write that touches the command bytes, and they are gated by the I/O-enable and memory-enable bits of the command register. The region sizes and type bits are parameters. The identity, class and header-type reset values are parameters as well.

Top module: `cfg_space`

## Requirements
- R1: After reset, bytes 0x00–0x01 hold VENDOR and 0x02–0x03 hold DEVICE (little-endian), 0x08 holds REV, 0x09–0x0B hold CLASS (low byte first), and 0x0E holds HDR. Every other byte is zero, and all seven map_valid bits are low with map_base zero.
- R2: The read size code is 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes. Data is little-endian, with the byte at req_addr in bits 7:0. A four-byte read at an offset above 0xFC returns two bytes instead, and a two-byte read above 0xFE returns one byte. Unused upper bits read as zero.
- R3: A write that does not take the base-register path stores its bytes one at a time, with wdata[7:0] going to req_addr. It skips protected bytes and drops any byte whose offset would exceed 0xFF.
- R4: When HDR is 0x00 or 0x80, these bytes are protected: 0x00–0x03, 0x08–0x0B, 0x0E, 0x3D, 0x10–0x27 and 0x30–0x33.
- R5: For any other HDR value, these bytes are protected: 0x00–0x03, 0x08–0x0B, 0x0E, 0x3D and 0x38–0x3B. The bytes at 0x10–0x27 and 0x30–0x33 are plain writable bytes.
- R6: A four-byte write whose offset lies in 0x10–0x27 selects base register n = (offset−0x10)/4. If region n has a nonzero size, the block stores wdata & ~(size−1) | type at the offset. A region with size 0 takes the plain byte path instead.
- R7: The ROM register is at 0x30 when HDR is 0x00 or 0x80, and at 0x38 otherwise. A four-byte write in its four-byte window stores wdata & (~(size−1) | 1), so bit 0 (enable) survives.
- R8: An I/O region (type bit 0 set) is valid only when command bit 0 is set. It is invalid if its masked base is 0, if base+size−1 is not above base, or if base+size−1 is 0x10000 or more.
- R9: A memory region is valid only when command bit 1 is set. It is invalid if its masked base is 0, if its end wraps, or if its end is 0xFFFFFFFF. The ROM region also needs its register bit 0 set. map_base carries the masked base when the region is valid, and zero otherwise.
- R10: The map outputs change only on the second clock edge after a write that takes the base-register path or that overlaps offsets 0x04–0x05. Other writes, including byte writes to base-register bytes under the bridge header, leave the map unchanged until the next such write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset into configuration space |
| req_size | input | 2 | 0 = byte, 1 = word, 2/3 = dword |
| req_wdata | input | 32 | Write data, little-endian |
| rd_data | output | 32 | Combinational read data for req_addr/req_size |
| map_valid | output | 7 | Per-region decoded-mapping valid; bit 6 is the ROM |
| map_base | output | 224 | Per-region decoded base, 32 bits each, region 0 lowest |

## Verification
The hardest state to reach is a stored base register that disagrees with the live map. This happens under the bridge header, where plain byte writes can rewrite base-register bytes without causing a remap, so the map keeps the old address until a command write follows. The stimulus reaches this state deliberately. It then mixes many seeded random accesses, biased toward the low 0x48 offsets, so that random command and base-register writes produce wrapping, zero and out-of-range bases under both header types.

// File: rtl/cfg_space.sv
module cfg_space #(
  parameter logic [15:0]  VENDOR   = 16'h1af4,
  parameter logic [15:0]  DEVICE   = 16'h1000,
  parameter logic [7:0]   REV      = 8'h01,
  parameter logic [23:0]  CLASS    = 24'h020000,
  parameter logic [7:0]   HDR      = 8'h00,
  parameter int           NBAR     = 6,
  parameter logic [(NBAR+1)*32-1:0] BAR_SIZE =
    {32'h800, 32'h8, 32'h0, 32'h10, 32'h0, 32'h1000, 32'h100},
  parameter logic [(NBAR+1)*4-1:0]  BAR_TYPE =
    {4'h0, 4'h1, 4'h0, 4'h0, 4'h0, 4'h8, 4'h1}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [7:0]              req_addr,
  input  logic [1:0]              req_size,
  input  logic [31:0]             req_wdata,
  output logic [31:0]             rd_data,
  output logic [NBAR:0]           map_valid,
  output logic [(NBAR+1)*32-1:0]  map_base
);
  localparam int NREG = NBAR + 1;

  logic [7:0] cfg [256];
  logic       pending;

  function automatic logic [7:0] rst_byte(input logic [7:0] a);
    case (a)
      8'h00: return VENDOR[7:0];
      8'h01: return VENDOR[15:8];
      8'h02: return DEVICE[7:0];
      8'h03: return DEVICE[15:8];
      8'h08: return REV;
      8'h09: return CLASS[7:0];
      8'h0a: return CLASS[15:8];
      8'h0b: return CLASS[23:16];
      8'h0e: return HDR;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic writable(input logic [7:0] a, input logic t0);
    logic ro;
    ro = (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0b) || a == 8'h0e || a == 8'h3d;
    if (t0) ro = ro || (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
    else    ro = ro || (a >= 8'h38 && a <= 8'h3b);
    return !ro;
  endfunction

  wire       is_t0   = (cfg[8'h0e] == 8'h00) || (cfg[8'h0e] == 8'h80);
  wire [7:0] rom_off = is_t0 ? 8'h30 : 8'h38;
  wire [2:0] nbytes  = (req_size == 2'd0) ? 3'd1 : (req_size == 2'd1) ? 3'd2 : 3'd4;
  wire       wr      = req_valid && req_write;

  logic        bar_hit;
  logic [2:0]  bar_idx;
  logic [31:0] bar_sz, bar_val;
  wire  [7:0]  rel = req_addr - 8'h10;

  always_comb begin
    bar_hit = 1'b0;
    bar_idx = 3'd0;
    if (nbytes == 3'd4) begin
      if (req_addr >= 8'h10 && req_addr <= 8'h27) begin
        bar_hit = 1'b1;
        bar_idx = rel[4:2];
      end else if (req_addr >= rom_off && req_addr <= rom_off + 8'd3) begin
        bar_hit = 1'b1;
        bar_idx = 3'(NBAR);
      end
    end
    bar_sz = BAR_SIZE[32*bar_idx +: 32];
    if (bar_sz == 32'd0) bar_hit = 1'b0;
    if (bar_idx == 3'(NBAR)) bar_val = req_wdata & (~(bar_sz - 32'd1) | 32'd1);
    else bar_val = (req_wdata & ~(bar_sz - 32'd1)) | {28'd0, BAR_TYPE[4*bar_idx +: 4]};
  end

  wire [8:0] wr_end = {1'b0, req_addr} + {6'd0, nbytes};
  wire       remap  = wr && (bar_hit || (wr_end > 9'd4 && req_addr < 8'd6));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) cfg[i] <= rst_byte(8'(i));
      pending <= 1'b0;
    end else begin
      pending <= remap;
      if (wr) begin
        if (bar_hit) begin
          for (int k = 0; k < 4; k++) cfg[8'(req_addr + 8'(k))] <= bar_val[8*k +: 8];
        end else begin
          for (int k = 0; k < 4; k++)
            if (k < int'(nbytes) && ({1'b0, req_addr} + 9'(k)) <= 9'd255 &&
                writable(8'(req_addr + 8'(k)), is_t0))
              cfg[8'(req_addr + 8'(k))] <= req_wdata[8*k +: 8];
        end
      end
    end
  end

  always_comb begin
    if (nbytes == 3'd4 && req_addr <= 8'hfc)
      rd_data = {cfg[8'(req_addr + 8'd3)], cfg[8'(req_addr + 8'd2)],
                 cfg[8'(req_addr + 8'd1)], cfg[req_addr]};
    else if (nbytes != 3'd1 && req_addr <= 8'hfe)
      rd_data = {16'd0, cfg[8'(req_addr + 8'd1)], cfg[req_addr]};
    else
      rd_data = {24'd0, cfg[req_addr]};
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam logic [31:0] SZ = BAR_SIZE[32*r +: 32];
    localparam bit          IO = (r < NBAR) && BAR_TYPE[4*r];
    logic [7:0]  off;
    logic [31:0] bv, base, last, base_q;
    logic        ok, vld_q;

    always_comb begin
      off  = (r < NBAR) ? 8'(16 + 4 * r) : rom_off;
      bv   = {cfg[8'(off + 8'd3)], cfg[8'(off + 8'd2)], cfg[8'(off + 8'd1)], cfg[off]};
      base = bv & ~(SZ - 32'd1);
      last = base + SZ - 32'd1;
      if (SZ == 32'd0)
        ok = 1'b0;
      else if (IO)
        ok = cfg[8'h04][0] && base != 0 && last > base && last < 32'h10000;
      else
        ok = cfg[8'h04][1] && base != 0 && last > base && last != 32'hffffffff &&
             ((r < NBAR) || bv[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        base_q <= 32'd0;
      end else if (pending) begin
        vld_q  <= ok;
        base_q <= ok ? base : 32'd0;
      end
    end

    assign map_valid[r]          = vld_q;
    assign map_base[32*r +: 32]  = base_q;
  end
endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
  parameter int NBAR = 6,
  parameter logic [(NBAR+1)*32-1:0] BAR_SIZE = '0,
  parameter logic [(NBAR+1)*4-1:0]  BAR_TYPE = '0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr,
  input logic [31:0]            id_bytes,
  input logic [NBAR:0]          map_valid,
  input logic [(NBAR+1)*32-1:0] map_base
);
  p_id_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(id_bytes));

  p_map_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr) && !$past(wr, 2)) |-> ($stable(map_valid) && $stable(map_base)));

  for (genvar r = 0; r <= NBAR; r++) begin : g_chk
    localparam logic [31:0] SZ = BAR_SIZE[32*r +: 32];
    localparam bit          IO = (r < NBAR) && BAR_TYPE[4*r];

    p_base_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      map_valid[r] |-> map_base[32*r +: 32] != 32'd0);

    p_base_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      map_valid[r] |-> (map_base[32*r +: 32] & (SZ - 32'd1)) == 32'd0);

    p_invalid_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !map_valid[r] |-> map_base[32*r +: 32] == 32'd0);

    if (IO) begin : g_io
      p_io_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        map_valid[r] |-> ({1'b0, map_base[32*r +: 32]} + {1'b0, SZ} - 33'd1) < 33'h10000);
    end else begin : g_mem
      p_mem_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        map_valid[r] |-> (map_base[32*r +: 32] + SZ - 32'd1) != 32'hffffffff);
    end
  end
endmodule

bind cfg_space cfg_space_chk #(.NBAR(NBAR), .BAR_SIZE(BAR_SIZE), .BAR_TYPE(BAR_TYPE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr       (req_valid && req_write),
  .id_bytes ({cfg[3], cfg[2], cfg[1], cfg[0]}),
  .map_valid(map_valid),
  .map_base (map_base)
);

// File: tb/tb_cfg_space.sv
module tb_cfg_space;
  localparam logic [15:0]  VID = 16'h1af4;
  localparam logic [15:0]  DID = 16'h1000;
  localparam logic [7:0]   RV  = 8'h01;
  localparam logic [23:0]  CLS = 24'h020000;
  localparam logic [223:0] BSZ = {32'h800, 32'h8, 32'h0, 32'h10, 32'h0, 32'h1000, 32'h100};
  localparam logic [27:0]  BTY = {4'h0, 4'h1, 4'h0, 4'h0, 4'h0, 4'h8, 4'h1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic [6:0] va, vb;
  logic [223:0] ba, bb;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  cfg_space #(.VENDOR(VID), .DEVICE(DID), .REV(RV), .CLASS(CLS), .HDR(8'h00),
              .BAR_SIZE(BSZ), .BAR_TYPE(BTY)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rd_data(rd_a), .map_valid(va), .map_base(ba));

  cfg_space #(.VENDOR(VID), .DEVICE(DID), .REV(RV), .CLASS(CLS), .HDR(8'h01),
              .BAR_SIZE(BSZ), .BAR_TYPE(BTY)) dut_b (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rd_data(rd_b), .map_valid(vb), .map_base(bb));

  logic [7:0]   m  [2][256];
  logic [6:0]   ev [2];
  logic [223:0] eb [2];

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit hdr0(input int k);
    return m[k][14] == 8'h00 || m[k][14] == 8'h80;
  endfunction

  function automatic bit prot(input int a, input bit t0);
    if (a <= 3 || (a >= 8 && a <= 11) || a == 14 || a == 61) return 1;
    if (t0) return (a >= 16 && a <= 39) || (a >= 48 && a <= 51);
    return a >= 56 && a <= 59;
  endfunction

  task automatic model_init();
    for (int k = 0; k < 2; k++) begin
      for (int a = 0; a < 256; a++) m[k][a] = 8'h00;
      m[k][0] = VID[7:0]; m[k][1] = VID[15:8]; m[k][2] = DID[7:0]; m[k][3] = DID[15:8];
      m[k][8] = RV; m[k][9] = CLS[7:0]; m[k][10] = CLS[15:8]; m[k][11] = CLS[23:16];
      m[k][14] = (k == 0) ? 8'h00 : 8'h01;
      ev[k] = '0; eb[k] = '0;
    end
  endtask

  task automatic model_remap(input int k);
    int rom;
    rom = hdr0(k) ? 48 : 56;
    for (int r = 0; r < 7; r++) begin
      logic [31:0] sz, v, b, e;
      int off;
      bit good;
      sz  = BSZ[32*r +: 32];
      off = (r < 6) ? 16 + 4 * r : rom;
      v   = {m[k][off+3], m[k][off+2], m[k][off+1], m[k][off]};
      b   = v & ~(sz - 1);
      e   = b + sz - 1;
      if (sz == 0) good = 0;
      else if (r < 6 && BTY[4*r]) good = m[k][4][0] && b != 0 && e > b && e < 32'h10000;
      else good = m[k][4][1] && b != 0 && e > b && e != 32'hffffffff && (r < 6 || v[0]);
      ev[k][r] = good;
      eb[k][32*r +: 32] = good ? b : 32'd0;
    end
  endtask

  task automatic model_write(input int k, input int a, input int sz, input logic [31:0] d);
    int n, idx, rom;
    bit hit, trig;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    rom = hdr0(k) ? 48 : 56;
    hit = 0; idx = 0;
    if (n == 4 && a >= 16 && a <= 39) begin hit = 1; idx = (a - 16) / 4; end
    else if (n == 4 && a >= rom && a <= rom + 3) begin hit = 1; idx = 6; end
    if (hit && BSZ[32*idx +: 32] == 0) hit = 0;
    if (hit) begin
      logic [31:0] s, w;
      s = BSZ[32*idx +: 32];
      w = (idx == 6) ? (d & (~(s - 1) | 32'd1)) : ((d & ~(s - 1)) | {28'd0, BTY[4*idx +: 4]});
      for (int j = 0; j < 4; j++) m[k][a+j] = w[8*j +: 8];
    end else begin
      for (int j = 0; j < n; j++)
        if (a + j <= 255 && !prot(a + j, hdr0(k))) m[k][a+j] = d[8*j +: 8];
    end
    trig = hit || (a + n > 4 && a < 6);
    if (trig) model_remap(k);
  endtask

  function automatic logic [31:0] model_read(input int k, input int a, input int sz);
    int n;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (n == 4 && a <= 252) return {m[k][a+3], m[k][a+2], m[k][a+1], m[k][a]};
    if (n >= 2 && a <= 254) return {16'd0, m[k][a+1], m[k][a]};
    return {24'd0, m[k][a]};
  endfunction

  task automatic check_maps(input string req);
    chk(va == ev[0] && ba == eb[0], req, {25'd0, va, ba}, {25'd0, ev[0], eb[0]});
    chk(vb == ev[1] && bb == eb[1], req, {25'd0, vb, bb}, {25'd0, ev[1], eb[1]});
  endtask

  task automatic op(input bit w, input int a, input int sz, input logic [31:0] d, input string req);
    req_valid = 1'b1; req_write = w; req_addr = 8'(a); req_size = 2'(sz); req_wdata = d;
    #1;
    if (!w) begin
      chk(rd_a == model_read(0, a, sz), req, rd_a, model_read(0, a, sz));
      chk(rd_b == model_read(1, a, sz), req, rd_b, model_read(1, a, sz));
    end
    @(posedge clk);
    if (w) begin model_write(0, a, sz, d); model_write(1, a, sz, d); end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_maps(req);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_cf9));
    model_init();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset contents and idle map
    check_maps("R1");
    for (int a = 0; a < 256; a++) op(1'b0, a, 0, 32'd0, "R1");

    // R2 little-endian and end-of-space fallbacks
    op(1'b0, 8'h00, 2, 32'd0, "R2");
    chk(rd_a == {DID, VID}, "R2", rd_a, {DID, VID});
    op(1'b0, 8'h08, 3, 32'd0, "R2");
    op(1'b0, 8'hfd, 2, 32'd0, "R2");
    op(1'b0, 8'hff, 1, 32'd0, "R2");

    // R3 byte-wise write clipped at 0xFF
    op(1'b1, 8'hfe, 2, 32'hAABBCCDD, "R3");
    op(1'b0, 8'hfe, 1, 32'd0, "R3");
    chk(rd_a == 32'h0000CCDD, "R3", rd_a, 32'h0000CCDD);
    op(1'b1, 8'h40, 2, 32'h11223344, "R3");
    op(1'b0, 8'h40, 2, 32'd0, "R3");

    // R4 / R5 protection: byte write to BAR0 low byte and to 0x3D
    op(1'b1, 8'h10, 0, 32'h000000A5, "R4");
    op(1'b0, 8'h10, 0, 32'd0, "R4");
    chk(rd_a == 32'h0 && rd_b == 32'hA5, "R5", {rd_a, rd_b}, {32'h0, 32'hA5});
    op(1'b1, 8'h3c, 1, 32'h0000FFFF, "R4");
    op(1'b0, 8'h3c, 1, 32'd0, "R5");
    op(1'b1, 8'h38, 2, 32'h12345678, "R5");
    op(1'b0, 8'h38, 2, 32'd0, "R5");

    // R6 BAR masking with type bits
    op(1'b1, 8'h10, 2, 32'hFFFFFFFF, "R6");
    op(1'b0, 8'h10, 2, 32'd0, "R6");
    chk(rd_a == 32'hFFFFFF01, "R6", rd_a, 32'hFFFFFF01);
    op(1'b1, 8'h18, 2, 32'h12345678, "R6");
    op(1'b0, 8'h18, 2, 32'd0, "R6");

    // R8 I/O decode
    op(1'b1, 8'h04, 1, 32'h00000001, "R8");
    op(1'b1, 8'h10, 2, 32'h0000C000, "R8");
    chk(va[0] && ba[31:0] == 32'hC000, "R8", {va[0], ba[31:0]}, {1'b1, 32'hC000});
    op(1'b1, 8'h10, 2, 32'h0000FF00, "R8");
    chk(va[0] == 1'b1, "R8", va[0], 1'b1);
    op(1'b1, 8'h10, 2, 32'h00010000, "R8");
    chk(va[0] == 1'b0, "R8", va[0], 1'b0);
    op(1'b1, 8'h10, 2, 32'h00000000, "R8");
    op(1'b1, 8'h24, 2, 32'h0000FFF8, "R8");

    // R9 / R7 memory and ROM decode
    op(1'b1, 8'h04, 1, 32'h00000003, "R9");
    op(1'b1, 8'h14, 2, 32'hFEBF0000, "R9");
    chk(va[1] && ba[63:32] == 32'hFEBF0000, "R9", {va[1], ba[63:32]}, {1'b1, 32'hFEBF0000});
    op(1'b1, 8'h14, 2, 32'hFFFFF000, "R9");
    chk(va[1] == 1'b0, "R9", va[1], 1'b0);
    op(1'b1, 8'h30, 2, 32'hFE000000, "R7");
    chk(va[6] == 1'b0, "R7", va[6], 1'b0);
    op(1'b1, 8'h30, 2, 32'hFE0007FF, "R7");
    op(1'b0, 8'h30, 2, 32'd0, "R7");
    chk(rd_a == 32'hFE000001 && va[6] && ba[223:192] == 32'hFE000000, "R7",
        {rd_a, va[6], ba[223:192]}, {32'hFE000001, 1'b1, 32'hFE000000});
    op(1'b1, 8'h38, 2, 32'hFD000801, "R7");
    op(1'b0, 8'h38, 2, 32'd0, "R7");

    // R10 bridge: byte writes to BAR bytes do not remap until a command write
    op(1'b1, 8'h10, 2, 32'h0000C000, "R10");
    op(1'b1, 8'h11, 0, 32'h000000D0, "R10");
    chk(vb[0] && bb[31:0] == 32'hC000, "R10", bb[31:0], 32'hC000);
    op(1'b1, 8'h04, 0, 32'h00000003, "R10");
    chk(vb[0] && bb[31:0] == 32'hD000, "R10", bb[31:0], 32'hD000);

    // seeded random mix of all requirements
    for (int i = 0; i < 1500; i++) begin
      int a, s;
      bit w;
      logic [31:0] d;
      a = ($urandom % 8 == 0) ? int'($urandom % 256) : int'($urandom % 72);
      s = int'($urandom % 4);
      w = ($urandom % 3) != 0;
      d = $urandom;
      if ($urandom % 4 == 0) d = d & 32'h0000FFF7;
      op(w, a, s, d, "R3 R6 R8 R9 R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule